// File: doc/BRIEF.md
# Debug Event Sequencer with Sticky Status

This block watches the debug-relevant events of a processor core and keeps a set of sticky occurrence flags that a debug port reads. It can run a three-step chain: a breakpoint A match arms breakpoint B detection. A breakpoint B match then starts a loadable trace counter. The counter counts retired instructions down, and when it reaches zero the core is asked to enter debug mode.

A software breakpoint also raises the debug-entry request directly. A FIFO freeze event is recorded as a flag of its own. The core's operating state is reported as a 2-bit mode field.

The flags and the arm chain are cleared together, in two cases. One is a test-logic reset. The other is a resume strobe whose GO and EX qualifiers are both high. A resume with GO alone changes nothing.

Top module: `dbg_event_seq`

## Requirements
- R1: With `seq_en` high and the chain idle, a `bkpt_a` strobe sets `flg_arma` on the next cycle and arms breakpoint B detection.
- R2: With `seq_en` high and B armed, a `bkpt_b` strobe sets `flg_armb` on the next cycle and starts the trace counter. A `bkpt_b` strobe while the chain is idle changes no flag.
- R3: `cnt_load` loads `cnt_val` into the trace counter. Once started and with `trace_en` high, the counter decrements by one per `instr_ret` strobe. It stays at zero once there. The strobe that takes it from one to zero raises `debug_req` and sets `flg_trc` on the next cycle. With `trace_en` low the counter does not move.
- R4: A `sw_bkpt` strobe raises `debug_req` and sets `flg_sw` on the next cycle.
- R5: A `fifo_frz` strobe sets `flg_frz` on the next cycle.
- R6: No occurrence flag falls unless a clear condition (R7) was present in the previous cycle.
- R7: A clear condition is either `test_rst` high, or `resume` high together with both `res_go` and `res_ex`. On the cycle after a clear condition, all five flags are 0, the chain is idle and `debug_req` is 0. Events in the clearing cycle are dropped.
- R8: `resume` with `res_go` high and `res_ex` low leaves the flags and the arm chain unchanged.
- R9: With `seq_en` low, `bkpt_a` and `bkpt_b` change neither `flg_arma`, `flg_armb` nor the arm chain.
- R10: `core_mode` is 2'b10 when `core_debug` is high, 2'b01 when only `core_lowpwr` is high, and 2'b00 otherwise. 2'b11 is never produced.
- R11: `debug_req` lasts one cycle per triggering event. It is never high without `flg_sw` or `flg_trc` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| test_rst | input | 1 | Synchronous test-logic reset |
| seq_en | input | 1 | Sequential (chained) mode enable |
| trace_en | input | 1 | Trace mode enable |
| bkpt_a | input | 1 | Breakpoint A match strobe |
| bkpt_b | input | 1 | Breakpoint B match strobe |
| sw_bkpt | input | 1 | Software breakpoint strobe |
| fifo_frz | input | 1 | FIFO freeze strobe |
| instr_ret | input | 1 | Retired-instruction strobe |
| cnt_load | input | 1 | Load trace counter |
| cnt_val | input | CNT_W | Trace counter load value |
| resume | input | 1 | Debug-exit strobe |
| res_go | input | 1 | GO qualifier of the exit strobe |
| res_ex | input | 1 | EX qualifier of the exit strobe |
| core_lowpwr | input | 1 | Core is in stop, doze or wait |
| core_debug | input | 1 | Core is in debug mode |
| debug_req | output | 1 | Debug-entry request pulse |
| flg_sw | output | 1 | Software breakpoint occurred |
| flg_trc | output | 1 | Trace count expired |
| flg_frz | output | 1 | FIFO freeze occurred |
| flg_armb | output | 1 | Breakpoint B armed the counter |
| flg_arma | output | 1 | Breakpoint A armed breakpoint B |
| core_mode | output | 2 | Processor mode field |

## Verification
The hardest state to reach from the ports is trace-count expiry. It needs the whole chain: a cleared chain, a loaded count, an A strobe, a B strobe, and then exactly the right number of retired-instruction strobes with trace enabled. The stimulus walks this chain for every count from 1 to 6. It checks that no request appears one strobe early, that the request appears on the last strobe, and that a further strobe does nothing once the counter sits at zero.

// File: rtl/dbg_event_seq.sv
module dbg_event_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_rst,
  input  logic             seq_en,
  input  logic             trace_en,
  input  logic             bkpt_a,
  input  logic             bkpt_b,
  input  logic             sw_bkpt,
  input  logic             fifo_frz,
  input  logic             instr_ret,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             resume,
  input  logic             res_go,
  input  logic             res_ex,
  input  logic             core_lowpwr,
  input  logic             core_debug,
  output logic             debug_req,
  output logic             flg_sw,
  output logic             flg_trc,
  output logic             flg_frz,
  output logic             flg_armb,
  output logic             flg_arma,
  output logic [1:0]       core_mode
);

  typedef enum logic [1:0] {ARM_IDLE, ARM_B, ARM_CNT} arm_t;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  arm_t             arm;
  logic [CNT_W-1:0] cnt;

  wire clr    = test_rst | (resume & res_go & res_ex);
  wire hit_a  = seq_en & bkpt_a & (arm == ARM_IDLE);
  wire hit_b  = seq_en & bkpt_b & (arm == ARM_B);
  wire run    = (arm == ARM_CNT) & trace_en & instr_ret & (cnt != '0);
  wire expire = run & (cnt == CNT_ONE);

  assign core_mode = core_debug ? 2'b10 : (core_lowpwr ? 2'b01 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (test_rst)       cnt <= '0;
    else if (cnt_load)       cnt <= cnt_val;
    else if (run && !clr)    cnt <= cnt - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm       <= ARM_IDLE;
      debug_req <= 1'b0;
      flg_sw    <= 1'b0;
      flg_trc   <= 1'b0;
      flg_frz   <= 1'b0;
      flg_armb  <= 1'b0;
      flg_arma  <= 1'b0;
    end else if (clr) begin
      arm       <= ARM_IDLE;
      debug_req <= 1'b0;
      flg_sw    <= 1'b0;
      flg_trc   <= 1'b0;
      flg_frz   <= 1'b0;
      flg_armb  <= 1'b0;
      flg_arma  <= 1'b0;
    end else begin
      debug_req <= sw_bkpt | expire;
      if (hit_a) begin
        arm      <= ARM_B;
        flg_arma <= 1'b1;
      end
      if (hit_b) begin
        arm      <= ARM_CNT;
        flg_armb <= 1'b1;
      end
      if (sw_bkpt)  flg_sw  <= 1'b1;
      if (expire)   flg_trc <= 1'b1;
      if (fifo_frz) flg_frz <= 1'b1;
    end
  end

endmodule

module dbg_event_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_rst,
  input logic       seq_en,
  input logic       resume,
  input logic       res_go,
  input logic       res_ex,
  input logic       core_debug,
  input logic       core_lowpwr,
  input logic       debug_req,
  input logic       flg_sw,
  input logic       flg_trc,
  input logic       flg_frz,
  input logic       flg_armb,
  input logic       flg_arma,
  input logic [1:0] core_mode
);
  wire       clr_in = test_rst | (resume & res_go & res_ex);
  wire [4:0] flags  = {flg_sw, flg_trc, flg_frz, flg_armb, flg_arma};

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |=> (flags == 5'b0 && !debug_req)); // R7

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_in |=> ((flags & $past(flags)) == $past(flags))); // R6

  AST_SEQ_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en && !clr_in) |=> ($stable(flg_arma) && $stable(flg_armb))); // R9

  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
    flg_armb |-> flg_arma); // R2

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |-> (flg_sw || flg_trc)); // R11

  AST_MODE_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    core_debug |-> core_mode == 2'b10); // R10

  AST_MODE_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    core_mode != 2'b11); // R10

  AST_GO_ONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && res_go && !res_ex && !test_rst) |=>
      ((flags & $past(flags)) == $past(flags))); // R8
endmodule

bind dbg_event_seq dbg_event_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .test_rst(test_rst), .seq_en(seq_en),
  .resume(resume), .res_go(res_go), .res_ex(res_ex),
  .core_debug(core_debug), .core_lowpwr(core_lowpwr),
  .debug_req(debug_req), .flg_sw(flg_sw), .flg_trc(flg_trc),
  .flg_frz(flg_frz), .flg_armb(flg_armb), .flg_arma(flg_arma),
  .core_mode(core_mode)
);

// File: tb/test_dbg_event_seq.sv
module test_dbg_event_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_rst, seq_en, trace_en, bkpt_a, bkpt_b, sw_bkpt, fifo_frz;
  logic instr_ret, cnt_load, resume, res_go, res_ex, core_lowpwr, core_debug;
  logic [CNT_W-1:0] cnt_val;
  logic debug_req, flg_sw, flg_trc, flg_frz, flg_armb, flg_arma;
  logic [1:0] core_mode;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_seq #(.CNT_W(CNT_W)) i_dbg_event_seq (
    .clk(clk), .rst_n(rst_n), .test_rst(test_rst), .seq_en(seq_en),
    .trace_en(trace_en), .bkpt_a(bkpt_a), .bkpt_b(bkpt_b),
    .sw_bkpt(sw_bkpt), .fifo_frz(fifo_frz), .instr_ret(instr_ret),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .resume(resume),
    .res_go(res_go), .res_ex(res_ex), .core_lowpwr(core_lowpwr),
    .core_debug(core_debug), .debug_req(debug_req), .flg_sw(flg_sw),
    .flg_trc(flg_trc), .flg_frz(flg_frz), .flg_armb(flg_armb),
    .flg_arma(flg_arma), .core_mode(core_mode)
  );

  wire [4:0] flags = {flg_sw, flg_trc, flg_frz, flg_armb, flg_arma};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    test_rst = 0; bkpt_a = 0; bkpt_b = 0; sw_bkpt = 0; fifo_frz = 0;
    instr_ret = 0; cnt_load = 0; resume = 0; res_go = 0; res_ex = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic step();
    tick(); quiet();
  endtask

  task automatic go_ex_clear();
    resume = 1; res_go = 1; res_ex = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    quiet(); seq_en = 0; trace_en = 0; cnt_val = '0; core_lowpwr = 0; core_debug = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    tick();
    check("R7 reset flags", flags, 0);
    check("R11 reset req", debug_req, 0);

    // R10 mode field sweep
    for (int m = 0; m < 4; m++) begin
      core_debug = m[1]; core_lowpwr = m[0]; #1;
      check("R10 mode", core_mode, m[1] ? 2 : (m[0] ? 1 : 0));
    end
    core_debug = 0; core_lowpwr = 0;

    // R9 sequential mode off: all A/B combos ignored
    for (int v = 0; v < 4; v++) begin
      bkpt_a = v[0]; bkpt_b = v[1]; step();
      check("R9 seq off arm flags", flags, 0);
    end
    seq_en = 1; bkpt_b = 1; step();
    check("R9 chain stayed idle", flags, 0);

    // R2 B before A ignored
    go_ex_clear();
    bkpt_b = 1; step();
    check("R2 B while idle", flags, 0);

    // R1/R2/R3 chained expiry for counts 1..6
    trace_en = 1;
    for (int n = 1; n <= 6; n++) begin
      go_ex_clear();
      cnt_load = 1; cnt_val = CNT_W'(n); step();
      bkpt_a = 1; step();
      check("R1 A arms", flags, 5'b00001);
      bkpt_b = 1; step();
      check("R2 B starts counter", flags, 5'b00011);
      for (int k = 0; k < n - 1; k++) begin
        instr_ret = 1; step();
        check("R3 no early expiry", debug_req, 0);
      end
      instr_ret = 1; step();
      check("R3 expiry req", debug_req, 1);
      check("R3 expiry flag", flags, 5'b01011);
      tick();
      check("R11 req one cycle", debug_req, 0);
      instr_ret = 1; step();
      check("R3 hold at zero", debug_req, 0);
    end

    // R3 trace disabled freezes counter
    go_ex_clear();
    cnt_load = 1; cnt_val = 2; step();
    bkpt_a = 1; step(); bkpt_b = 1; step();
    trace_en = 0;
    for (int k = 0; k < 3; k++) begin
      instr_ret = 1; step();
      check("R3 trace off no count", debug_req, 0);
    end
    trace_en = 1;
    instr_ret = 1; step();
    check("R3 resumed count no req", debug_req, 0);
    instr_ret = 1; step();
    check("R3 resumed count req", debug_req, 1);

    // R4 software breakpoint, R5 freeze
    go_ex_clear();
    sw_bkpt = 1; step();
    check("R4 sw req", debug_req, 1);
    check("R4 sw flag", flags, 5'b10000);
    tick();
    check("R11 sw req one cycle", debug_req, 0);
    fifo_frz = 1; step();
    check("R5 freeze flag", flags, 5'b10100);
    check("R5 freeze no req", debug_req, 0);

    // R8 GO without EX; R6 sticky
    bkpt_a = 1; step();
    resume = 1; res_go = 1; res_ex = 0; step();
    check("R8 go only keeps", flags, 5'b10101);
    resume = 1; res_go = 0; res_ex = 1; step();
    check("R6 ex only keeps", flags, 5'b10101);
    bkpt_a = 1; step();
    check("R8 chain still armed B", flags, 5'b10101);
    bkpt_b = 1; step();
    check("R8 B after go-only", flags, 5'b10111);

    // R7 test reset clears, same-cycle events dropped
    test_rst = 1; sw_bkpt = 1; fifo_frz = 1; step();
    check("R7 test reset flags", flags, 0);
    check("R7 test reset req", debug_req, 0);
    bkpt_b = 1; step();
    check("R7 chain idle after reset", flags, 0);
    bkpt_a = 1; step();
    resume = 1; res_go = 1; res_ex = 1; sw_bkpt = 1; step();
    check("R7 go+ex clears", flags, 0);
    check("R7 go+ex drops req", debug_req, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule